// File: doc/BRIEF.md
# Multi-Mode Event Timer with Overflow Interrupt

This block is one timer channel. It advances on a single-cycle `tick` pulse, which may come from an internal clock divider or from a synchronised external event. Counting happens only while `run` is high. The count lives in two byte-wide registers, a low byte and a high byte. A small register bus reads and writes both bytes and the overflow flag.

The `mode` input selects one of four ways of using the register pair:

- a 13-bit counter built from a 5-bit prescaler in the low byte that feeds the high byte;
- a 16-bit counter with the low byte carrying into the high byte;
- an 8-bit counter in the low byte that reloads from the high byte;
- a halt mode that freezes the count.

Every overflow sets a flag. The interrupt request is that flag gated by a local enable and a global enable. An acknowledge pulse from the interrupt controller clears the flag.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal. Bus writes take effect on the next clock edge, and bus reads are combinational.

Top module: `ovf_timer`

## Requirements
- R1: After reset the low byte, the high byte and the overflow flag are all zero, and `irq` is low.
- R2: Mode 2'b00, prescaled counting:
  - Each accepted tick increments bits [4:0] of the low byte modulo 32.
  - Each wrap of those five bits from 31 to 0 increments the high byte.
  - When the combined 13-bit value wraps from all ones to zero, the flag is set.
- R3: In mode 2'b00, bits [7:5] of the low byte keep whatever value was last written.
- R4: Mode 2'b01, cascade counting:
  - The high and low bytes act as one 16-bit counter.
  - Each accepted tick increments the low byte, and a low-byte carry increments the high byte.
  - The flag is set when the 16-bit value wraps from 0xFFFF to 0x0000.
- R5: Mode 2'b10, auto-reload:
  - Each accepted tick increments the low byte.
  - A tick arriving when the low byte is 0xFF loads the low byte from the high byte and sets the flag.
  - The high byte is never changed by counting in this mode.
- R6: In mode 2'b11 neither byte changes, whatever `run` and `tick` do.
- R7: A tick is accepted only in a cycle where `run` and `tick` are both high. No other cycle changes the count.
- R8: An `ack` pulse clears the flag on the next clock edge. If an overflow occurs in the same cycle as the acknowledge, the overflow wins and the flag stays set.
- R9: `irq` is high exactly when the flag, `irq_en` and `irq_gen` are all 1.
- R10: Bus register map and write priority:
  - Address 0 is the low byte, address 1 is the high byte, and address 2 bit 0 is the flag (bits [7:1] read as zero).
  - A bus write to any of these in the same cycle as a hardware update wins over that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run control; ticks are ignored while low |
| tick | input | 1 | Count-enable pulse, one cycle per event |
| mode | input | 2 | Count structure select (00 prescaled, 01 cascade, 10 reload, 11 halt) |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Bus address for both reads and writes |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Combinational bus read data for `addr` |
| ack | input | 1 | Interrupt acknowledge pulse; clears the flag |
| irq_en | input | 1 | Local interrupt enable for this timer |
| irq_gen | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Each counting mode is swept from a grid of preset byte pairs, chosen to sit on and just before every carry boundary. Each sweep runs forty ticks, with both bytes and the flag compared against an arithmetic model after every tick.

- The 0x1F/0xFE/0xFF presets separate a prescaler wrap from a full-byte carry and from a 13-bit or 16-bit wrap.
- Presets with upper low-byte bits set reveal any leakage into the three unused bits in prescaled mode.
- The reload sweeps show whether the reload takes the high byte or zero.

Directed patterns then cover ticks with `run` low, halt, the enable combinations of the interrupt, and same-cycle collisions between writes or acknowledges and overflows.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  typedef enum logic [1:0] {
    TM_PRESCALE = 2'b00,
    TM_CASCADE  = 2'b01,
    TM_RELOAD   = 2'b10,
    TM_HALT     = 2'b11
  } tmode_e;

  localparam logic [1:0] ADR_LO   = 2'd0;
  localparam logic [1:0] ADR_HI   = 2'd1;
  localparam logic [1:0] ADR_FLAG = 2'd2;
endpackage

// File: rtl/ovf_timer_count.sv
module ovf_timer_count
  import ovf_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              adv,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf
);
  localparam logic [BYTE_W-1:0] ONE_B = {{(BYTE_W-1){1'b0}}, 1'b1};
  localparam logic [PRE_W:0]    ONE_P = {{PRE_W{1'b0}}, 1'b1};

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [PRE_W:0]    pre_sum;
  logic [BYTE_W:0]   lo_sum;

  assign pre_sum = {1'b0, lo_q[PRE_W-1:0]} + ONE_P;
  assign lo_sum  = {1'b0, lo_q} + {1'b0, ONE_B};

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    ovf  = 1'b0;
    if (adv) begin
      case (mode)
        TM_PRESCALE: begin
          lo_n[PRE_W-1:0] = pre_sum[PRE_W-1:0];
          if (pre_sum[PRE_W]) begin
            hi_n = hi_q + ONE_B;
            ovf  = (hi_q == '1);
          end
        end
        TM_CASCADE: begin
          lo_n = lo_sum[BYTE_W-1:0];
          if (lo_sum[BYTE_W]) begin
            hi_n = hi_q + ONE_B;
            ovf  = (hi_q == '1);
          end
        end
        TM_RELOAD: begin
          if (lo_q == '1) begin
            lo_n = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_n = lo_sum[BYTE_W-1:0];
          end
        end
        default: ;
      endcase
    end
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_PRESCALE && !wr_lo) |=> $stable(lo_q[BYTE_W-1:PRE_W]));
  a_r5_reload_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_RELOAD && !wr_hi) |=> $stable(hi_q));
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_HALT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/ovf_timer_flag.sv
module ovf_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  input  logic wr,
  input  logic wr_val,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (wr)  flag_q <= wr_val;
    else if (set) flag_q <= 1'b1;
    else if (ack) flag_q <= 1'b0;
  end

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set && !wr) |=> !flag_q);
  a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !wr) |=> flag_q);
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              ack,
  input  logic              irq_en,
  input  logic              irq_gen,
  output logic              irq
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              ovf, flag_q;
  logic              wr_lo, wr_hi, wr_flag;

  assign wr_lo   = wr_en && (addr == ADR_LO);
  assign wr_hi   = wr_en && (addr == ADR_HI);
  assign wr_flag = wr_en && (addr == ADR_FLAG);

  ovf_timer_count #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (tmode_e'(mode)),
    .adv     (run && tick),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ovf     (ovf)
  );

  ovf_timer_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (ovf),
    .ack    (ack),
    .wr     (wr_flag),
    .wr_val (wr_data[0]),
    .flag_q (flag_q)
  );

  always_comb begin
    case (addr)
      ADR_LO:   rd_data = lo_q;
      ADR_HI:   rd_data = hi_q;
      ADR_FLAG: rd_data = {{(BYTE_W-1){1'b0}}, flag_q};
      default:  rd_data = '0;
    endcase
  end

  assign irq = flag_q && irq_en && irq_gen;
endmodule

// File: tb/ovf_timer_bench.sv
`timescale 1ns/1ps
module ovf_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, tick = 1'b0, wr_en = 1'b0, ack = 1'b0;
  logic irq_en = 1'b0, irq_gen = 1'b0;
  logic [1:0] mode = 2'b00, addr = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  logic [7:0] m_lo, m_hi;
  logic m_flag;

  always #2.5 clk = ~clk;

  ovf_timer u_ovf_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .mode(mode),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .ack(ack), .irq_en(irq_en), .irq_gen(irq_gen), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic step;
    @(posedge clk);
    #1;
    tick = 1'b0;
    wr_en = 1'b0;
    ack = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1;
    addr = a;
    wr_data = d;
    step();
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    rd(2'd0, v); chk(tag, v, m_lo);
    rd(2'd1, v); chk(tag, v, m_hi);
    rd(2'd2, v); chk(tag, v, {7'd0, m_flag});
  endtask

  task automatic model_tick(input logic [1:0] md);
    int c;
    case (md)
      2'b00: begin
        c = m_hi * 32 + m_lo[4:0] + 1;
        if (c == 8192) m_flag = 1'b1;
        c = c % 8192;
        m_hi = 8'(c / 32);
        m_lo = {m_lo[7:5], 5'(c % 32)};
      end
      2'b01: begin
        c = m_hi * 256 + m_lo + 1;
        if (c == 65536) m_flag = 1'b1;
        c = c % 65536;
        m_hi = 8'(c / 256);
        m_lo = 8'(c % 256);
      end
      2'b10: begin
        if (m_lo == 8'hFF) begin
          m_lo = m_hi;
          m_flag = 1'b1;
        end else begin
          m_lo = m_lo + 8'd1;
        end
      end
      default: ;
    endcase
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] los [5];
    logic [7:0] his [3];
    los = '{8'h00, 8'hE7, 8'hFE, 8'hFF, 8'h1F};
    his = '{8'h00, 8'hFF, 8'h7F};

    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    irq_en = 1'b1;
    irq_gen = 1'b1;

    // R1 reset state
    m_lo = 0; m_hi = 0; m_flag = 0;
    check_all("R1");
    chk("R1 irq", {7'd0, irq}, 8'd0);

    // R2, R3, R4, R5 sweeps
    run = 1'b1;
    for (int md = 0; md < 3; md++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int lo = 0; lo < 5; lo++) begin
          mode = 2'(md);
          wreg(2'd2, 8'd0);
          wreg(2'd0, los[lo]);
          wreg(2'd1, his[hi]);
          m_lo = los[lo]; m_hi = his[hi]; m_flag = 1'b0;
          for (int t = 0; t < 40; t++) begin
            tick = 1'b1;
            step();
            model_tick(2'(md));
            check_all(md == 0 ? "R2 R3" : (md == 1 ? "R4" : "R5"));
          end
        end
      end
    end

    // R6 halt
    mode = 2'b11;
    wreg(2'd0, 8'hFF); wreg(2'd1, 8'hFF); m_lo = 8'hFF; m_hi = 8'hFF;
    for (int t = 0; t < 5; t++) begin tick = 1'b1; step(); end
    check_all("R6");

    // R7 run low, and run high with no tick
    mode = 2'b01;
    run = 1'b0;
    for (int t = 0; t < 5; t++) begin tick = 1'b1; step(); end
    check_all("R7 run low");
    run = 1'b1;
    repeat (5) step();
    check_all("R7 no tick");

    // R8 ack clears; overflow beats ack
    wreg(2'd2, 8'd1);
    ack = 1'b1; step();
    rd(2'd2, v); chk("R8 ack", v, 8'd0);
    wreg(2'd0, 8'hFF); wreg(2'd1, 8'hFF);
    tick = 1'b1; ack = 1'b1; step();
    rd(2'd2, v); chk("R8 set wins", v, 8'd1);

    // R9 gating, flag now 1
    for (int k = 0; k < 4; k++) begin
      irq_en = k[0]; irq_gen = k[1];
      #0.5;
      chk("R9", {7'd0, irq}, {7'd0, k == 3});
    end
    wreg(2'd2, 8'd0);
    irq_en = 1'b1; irq_gen = 1'b1;
    #0.5;
    chk("R9 flag low", {7'd0, irq}, 8'd0);

    // R10 write wins over count and over flag set
    wreg(2'd0, 8'hFF); wreg(2'd1, 8'hFF);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd2; wr_data = 8'd0; step();
    rd(2'd2, v); chk("R10 flag write", v, 8'd0);
    rd(2'd0, v); chk("R10 lo counted", v, 8'h00);
    wreg(2'd0, 8'h10);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wr_data = 8'h55; step();
    rd(2'd0, v); chk("R10 lo write", v, 8'h55);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule